// File: doc/BRIEF.md
# Nibble-Field Priority Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources and tells the processor two things: the highest priority level that is currently requesting, and the vector number of the source that wins. Each source owns a 4-bit field in one of several 32-bit control words. The low three bits of a field hold the source's priority, where zero masks the source. The top bit is a write strobe for that field alone. Software can therefore change one source with a single store and leave the other seven fields in the word as they were.

A few sources, chosen by a parameter mask, are external pins. Each one passes through a two-flop synchronizer and an edge detector whose active edge is selected by a polarity word. A detected edge is latched as pending until software acknowledges it. Writing the field with its top bit set clears the latch and loads the priority bits in the same store. All other sources are level-sensitive: a source requests for as long as its synchronized input is high, and it needs no acknowledge.

Top module: `prio_intc`

## Requirements
- R1: After reset, every priority is 0, every pending latch is clear and every polarity bit is 0. All readable words return 0, `irq_level` is 0 and `irq_vector` equals VEC_BASE.
- R2: In a write to a control word, a field whose bit 3 is 1 loads its bits 2:0 as the new priority. A field whose bit 3 is 0 keeps its priority unchanged.
- R3: Source s (numbered from 1) lives in control word (s-1)/8 at bits [31-4*((s-1)%8) -: 4]. Field positions with no source read 0 and ignore writes. With 28 sources, bits 15:0 of word 3 are such positions.
- R4: Reading a control word returns, for each field, the source's pending status in bit 3 and its priority in bits 2:0.
- R5: An internal source is pending while its input, after a two-cycle synchronizer, is high. It stops being pending as soon as the synchronized input falls, and it latches nothing.
- R6: An external source latches pending on its active edge and stays pending after the input returns to its idle level. The polarity word is at address NUM_REG (4 by default), with bit s-1 for source s. A value of 0 selects the rising edge and 1 selects the falling edge.
- R7: Writing an external source's field with bit 3 set clears its pending latch. The same store loads the priority from bits 2:0.
- R8: `irq_level` is the largest priority among pending sources whose priority is non-zero. `irq_vector` is VEC_BASE plus the number of the lowest-numbered source at that level. When no source qualifies, the outputs are 0 and VEC_BASE.
- R9: A source with priority 0 never drives the outputs. An external edge on such a source still latches and is visible in bit 3 of its field on read.
- R10: Polarity bits of internal sources read 0 and ignore writes. Addresses above NUM_REG read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word select |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| src_in | input | NUM_SRC | Request inputs; bit i is source i+1 |
| irq_level | output | 3 | Winning priority level, 0 when none |
| irq_vector | output | VEC_W | VEC_BASE plus winning source number |

## Verification
The bench builds the block with its default parameters: 28 sources, external mask 0x0600000F (sources 1–4, 26 and 27) and VEC_BASE 64. With these values every field position, the partly used last word, and both the edge and the level path are reachable. The bench sweeps every source through priority load, request, release and acknowledge, one at a time. It then runs tie sweeps at equal priority and staircase priority patterns, and checks the priority-zero latch and both polarities. Expected read words, levels and vectors come from a model built from the requirements.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_SRC  = 28,
  parameter logic [NUM_SRC-1:0] EXT_MASK = 28'h0600000F,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [2:0]        irq_level,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam int NUM_REG = (NUM_SRC + 7) / 8;
  localparam int ID_W    = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0]   sync1, sync2, sync3, pend, pol;
  logic [3*NUM_SRC-1:0] prio_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0; sync2 <= '0; sync3 <= '0;
    end else begin
      sync1 <= src_in; sync2 <= sync1; sync3 <= sync2;
    end
  end

  wire [NUM_SRC-1:0] edge_hit =
    EXT_MASK & ((sync2 & ~sync3 & ~pol) | (~sync2 & sync3 & pol));
  wire pol_wr = wr_en && (addr == ADDR_W'(NUM_REG));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int HI = 31 - 4 * (i % 8);
    wire fld_wr = wr_en && (addr == ADDR_W'(i / 8)) && wr_data[HI];
    logic [2:0] prio;

    always_ff @(posedge clk) begin
      if (rst)         prio <= '0;
      else if (fld_wr) prio <= wr_data[HI-1 -: 3];
    end
    assign prio_flat[3*i +: 3] = prio;

    if (EXT_MASK[i]) begin : g_ext
      logic p, pl;
      always_ff @(posedge clk) begin
        if (rst)              p <= 1'b0;
        else if (edge_hit[i]) p <= 1'b1;
        else if (fld_wr)      p <= 1'b0;
        if (rst)              pl <= 1'b0;
        else if (pol_wr)      pl <= wr_data[i];
      end
      assign pend[i] = p;
      assign pol[i]  = pl;
    end else begin : g_int
      assign pend[i] = sync2[i];
      assign pol[i]  = 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(NUM_REG))
      rd_data[NUM_SRC-1:0] = pol;
    else
      for (int i = 0; i < NUM_SRC; i++)
        if (addr == ADDR_W'(i / 8))
          rd_data[31 - 4*(i%8) -: 4] = {pend[i], prio_flat[3*i +: 3]};
  end

  logic [2:0]      best_lvl;
  logic [ID_W-1:0] best_id;
  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (pend[i] && prio_flat[3*i +: 3] > best_lvl) begin
        best_lvl = prio_flat[3*i +: 3];
        best_id  = ID_W'(i + 1);
      end
  end

  assign irq_level  = best_lvl;
  assign irq_vector = VEC_W'(VEC_BASE) + VEC_W'(best_id);
endmodule

module prio_intc_chk #(
  parameter int NUM_SRC  = 28,
  parameter logic [NUM_SRC-1:0] EXT_MASK = 28'h0600000F,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int ADDR_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] pol,
  input logic [3*NUM_SRC-1:0] prio_flat,
  input logic [2:0]        irq_level,
  input logic [VEC_W-1:0]  irq_vector
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (irq_level == 0 && prio_flat == '0));
  // R2
  hold_field_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0 && !wr_data[31]) |=> $stable(prio_flat[2:0]));
  // R6
  sticky_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && !(wr_en && addr == '0 && wr_data[31])) |=> pend[0]);
  // R8
  idle_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_level == 0) |-> (irq_vector == VEC_W'(VEC_BASE)));
  // R10
  pol_internal_chk: assert property (@(posedge clk) disable iff (rst)
    (pol & ~EXT_MASK) == '0);
endmodule

bind prio_intc prio_intc_chk #(
  .NUM_SRC(NUM_SRC), .EXT_MASK(EXT_MASK), .VEC_W(VEC_W),
  .VEC_BASE(VEC_BASE), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .pend(pend), .pol(pol), .prio_flat(prio_flat),
  .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  localparam int N = 28;
  localparam logic [N-1:0] EXT = 28'h0600000F;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [N-1:0] src_in = 0;
  logic [2:0] irq_level;
  logic [7:0] irq_vector;

  int checks = 0, fails = 0;
  logic [2:0] m_prio [N];
  logic [N-1:0] m_pend = 0, m_pol = 0, m_in = 0;

  prio_intc u_dut (.clk, .rst, .wr_en, .addr, .wr_data, .rd_data,
                   .src_in, .irq_level, .irq_vector);

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int a);
    logic [31:0] w = 0;
    if (a == 4) return {4'b0, m_pol};
    for (int i = 0; i < N; i++)
      if (i / 8 == a) w[31 - 4*(i%8) -: 4] = {(EXT[i] ? m_pend[i] : m_in[i]), m_prio[i]};
    return w;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 4) m_pol = d[N-1:0] & EXT;
    else if (a < 4)
      for (int i = 0; i < N; i++)
        if (i / 8 == a && d[31 - 4*(i%8)]) begin
          m_prio[i] = d[30 - 4*(i%8) -: 3];
          if (EXT[i]) m_pend[i] = 0;
        end
  endtask

  task automatic drive(logic [N-1:0] v);
    for (int i = 0; i < N; i++)
      if (EXT[i] && ((!m_in[i] && v[i] && !m_pol[i]) || (m_in[i] && !v[i] && m_pol[i])))
        m_pend[i] = 1;
    m_in = v;
    @(negedge clk);
    src_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    int lvl = 0, id = 0;
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk(tag, rd_data, (a <= 4) ? exp_word(a) : 32'h0);
    end
    for (int i = 0; i < N; i++)
      if ((EXT[i] ? m_pend[i] : m_in[i]) && int'(m_prio[i]) > lvl) begin
        lvl = m_prio[i]; id = i + 1;
      end
    chk({tag, " level"}, 32'(irq_level), 32'(lvl));
    chk({tag, " vector"}, 32'(irq_vector), 32'(64 + id));
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_prio[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_all("R1 reset");

    // R2 R3 R4: one field at a time, other fields carry bit3=0 with garbage
    for (int s = 1; s <= 32; s++) begin
      int f = (s - 1) % 8;
      logic [31:0] d = 32'h77777777;
      d[31 - 4*f -: 4] = {1'b1, 3'((s * 3) % 7 + 1)};
      wr((s - 1) / 8, d);
      check_all("R2 R3 field write");
    end
    wr(3, 32'h0000FFFF);
    check_all("R3 unused fields");

    // R5 R6 R7 R8: each source alone
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] one = '0;
      one[i] = 1'b1;
      drive(one);
      check_all(EXT[i] ? "R6 edge latch" : "R5 level high");
      drive('0);
      check_all(EXT[i] ? "R6 sticky" : "R5 level low");
      if (EXT[i]) begin
        logic [31:0] d = 0;
        d[31 - 4*(i%8) -: 4] = {1'b1, m_prio[i]};
        wr(i / 8, d);
        check_all("R7 ack");
      end
    end

    // R8 ties at equal priority
    for (int a = 0; a < 4; a++) wr(a, 32'hCCCCCCCC);
    for (int s = 0; s < N; s++) begin
      logic [N-1:0] v = '0;
      for (int i = s; i < N; i++) if (!EXT[i]) v[i] = 1'b1;
      drive(v);
      check_all("R8 tie lowest number");
    end
    drive('0);
    for (int i = 0; i < N; i++) if (EXT[i]) begin
      logic [31:0] d = 0;
      d[31 - 4*(i%8) -: 4] = 4'hC;
      wr(i / 8, d);
    end

    // R8 staircase priorities
    for (int k = 0; k < 7; k++) begin
      for (int a = 0; a < 4; a++) begin
        logic [31:0] d = 0;
        for (int f = 0; f < 8; f++) d[31 - 4*f -: 4] = {1'b1, 3'((a * 8 + f + k) % 8)};
        wr(a, d);
      end
      drive(~EXT);
      check_all("R8 max level");
      drive(28'h0AAAAAA0 & ~EXT);
      check_all("R8 partial set");
      drive('0);
    end

    // R9 masked source still latches
    for (int a = 0; a < 4; a++) wr(a, 32'h88888888);
    drive(EXT);
    check_all("R9 masked latch");
    drive('0);
    wr(0, 32'h09990000);
    check_all("R9 partial ack");
    wr(0, 32'h88880000);
    wr(3, 32'h08800000);
    check_all("R7 ack all");

    // R6 R10 polarity
    wr(4, 32'hFFFFFFFF);
    check_all("R10 polarity mask");
    wr(3, 32'h0DD00000);
    drive(EXT);
    check_all("R6 falling ignores rise");
    drive('0);
    check_all("R6 falling latch");
    wr(3, 32'h0DD00000);
    wr(4, 32'h0);
    check_all("R10 polarity clear");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule